// File: doc/BRIEF.md
# Amplifier Fault Protection Supervisor

This block supervises the power stage of a stereo class-D amplifier. It takes already-digitized comparator flags: three junction temperature thresholds (125, 140 and 160 °C), overcurrent, supply overvoltage (above 20 V), supply undervoltage (below 8 V), a low 3.3 V rail (below 3 V), an output window fault (an output too close to a rail), PLL out of lock and PLL frequency below 45 MHz. From these it decides whether the bridge outputs switch or float. It also drives an open-drain diagnostic line, a thermal foldback request to the volume logic, and a bank of per-class fault flags that control software reads.

Every fault class has its own action. The lowest thermal threshold only asks for a volume reduction. Overtemperature and overcurrent float the outputs and recover on their own after a programmable delay in which the condition must stay clear. Supply, overdissipation, window and PLL faults float the outputs and recover through a full restart, which runs a soft-start interval before the outputs are enabled again. The PLL classes leave the diagnostic line released. All other floating classes pull it.

The controller has three states. ST_SOFT is the soft-start countdown and is also the state at reset. ST_FLOAT holds the outputs floated. ST_RUN lets the outputs switch. The transitions are named as follows. T_TRIP goes from any state to ST_FLOAT when a floating class is held. T_RESUME goes from ST_FLOAT to ST_RUN when every hold has cleared and no restart is owed. T_RESTART goes from ST_FLOAT to ST_SOFT when every hold has cleared and a restart is owed. T_READY goes from ST_SOFT to ST_RUN when the countdown reaches zero. A restart is owed when a restart-class fault occurred during the episode, or when a soft-start was cut short by a trip.

Top module: `amp_fault_supervisor`

## Requirements
- R1: While reset is held, out_enable, diag_pull and vol_reduce are 0 and fault_flags is 0. After reset is released the block is in soft-start, and out_enable rises exactly SOFT_CYC+1 clock edges after the first edge with reset released.
- R2: A clock edge that sees temp_warn high sets vol_reduce after that edge, and vol_reduce follows temp_warn with one cycle of delay. temp_warn alone never floats the outputs and never pulls diag_pull.
- R3: A clock edge that sees temp_crit or over_current high sets out_enable to 0 and diag_pull to 1 after that edge. Once the condition is low, both outputs return (out_enable 1, diag_pull 0) exactly DELAY_CYC+1 edges later, with no soft-start.
- R4: If temp_crit or over_current goes high again while its recovery delay is running, the delay restarts in full from the edge after the last high sample.
- R5: A clock edge that sees supply_high, supply_low, rail_low or out_window high sets out_enable to 0 and diag_pull to 1 after that edge. diag_pull is released one edge after every condition clears, and out_enable returns exactly SOFT_CYC+2 edges after that.
- R6: The overdissipation class is active only while temp_diss and over_current are both high. It is a restart-class fault. temp_diss alone has no effect on out_enable, diag_pull or fault_flags.
- R7: pll_unlock or pll_slow floats the outputs one edge after it is sampled high. diag_pull stays 0. Recovery takes the soft-start path, the same as R5.
- R8: When faults of several classes overlap, the outputs stay floated until every class has met its own recovery rule. If any of those classes needed a restart, the soft-start runs after the last class recovers.
- R9: fault_flags holds one sticky bit per class. The map is bit0 thermal foldback, bit1 overtemperature, bit2 overcurrent, bit3 overvoltage, bit4 undervoltage (supply_low or rail_low), bit5 overdissipation, bit6 output window, bit7 PLL unlock, bit8 PLL slow. A bit is set after any edge that sees its condition. It stays set after recovery until an edge with flag_rd high clears it, and a condition that is still present on that edge sets its bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_warn | input | 1 | Junction temperature above 125 °C |
| temp_diss | input | 1 | Junction temperature above 140 °C |
| temp_crit | input | 1 | Junction temperature above 160 °C |
| over_current | input | 1 | Output current above the limit |
| supply_high | input | 1 | Supply above 20 V |
| supply_low | input | 1 | Supply below 8 V |
| rail_low | input | 1 | 3.3 V rail below 3 V |
| out_window | input | 1 | An output is too close to a supply rail |
| pll_unlock | input | 1 | PLL out of lock |
| pll_slow | input | 1 | PLL frequency below 45 MHz |
| flag_rd | input | 1 | Read strobe; clears the fault flags |
| out_enable | output | 1 | 1 = outputs switch, 0 = outputs floated |
| diag_pull | output | 1 | 1 = pull the open-drain diagnostic line low |
| vol_reduce | output | 1 | Thermal foldback volume-reduction request |
| fault_flags | output | 9 | Sticky per-class fault flags, map in R9 |

## Verification
The bench builds the block with DELAY_CYC=5 and SOFT_CYC=4. These values are small enough to check every recovery edge exactly: the last still-floated cycle and the first enabled cycle, both for the direct path and for the soft-start path. A short delay also lets the bench raise a condition again in the middle of its recovery window, and lets it overlap an auto-recovering class with a restart class inside a short run.

// File: rtl/afp_pkg.sv
package afp_pkg;

    localparam int NUM_CLASS = 9;

    localparam int CL_FOLD  = 0;
    localparam int CL_OTEMP = 1;
    localparam int CL_OCUR  = 2;
    localparam int CL_OVOLT = 3;
    localparam int CL_UVOLT = 4;
    localparam int CL_ODISS = 5;
    localparam int CL_WIN   = 6;
    localparam int CL_LOCK  = 7;
    localparam int CL_FREQ  = 8;

    // classes that recover by themselves after a delay
    localparam logic [NUM_CLASS-1:0] AUTO_MASK    = 9'h006;
    // classes that float the outputs
    localparam logic [NUM_CLASS-1:0] FLOAT_MASK   = 9'h1FE;
    // classes that pull the diagnostic line
    localparam logic [NUM_CLASS-1:0] DIAG_MASK    = 9'h07E;
    // classes that demand a soft-start on recovery
    localparam logic [NUM_CLASS-1:0] RESTART_MASK = 9'h1F8;

    typedef enum logic [1:0] {
        ST_SOFT  = 2'd0,
        ST_FLOAT = 2'd1,
        ST_RUN   = 2'd2
    } sup_state_t;

endpackage

// File: rtl/afp_recovery_timer.sv
module afp_recovery_timer #(
    parameter int DELAY_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic hold
);
    localparam int DW = $clog2(DELAY_CYC + 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cond) begin
            cnt <= DW'(DELAY_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign hold = cond || (cnt != '0);
endmodule

// File: rtl/afp_flag_bank.sv
module afp_flag_bank #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         rd_clr,
    output logic [N-1:0] flags
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (rd_clr) begin
            flags <= set_vec;
        end else begin
            flags <= flags | set_vec;
        end
    end
endmodule

// File: rtl/afp_state_ctrl.sv
module afp_state_ctrl
    import afp_pkg::*;
#(
    parameter int SOFT_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic float_any,
    input  logic restart_any,
    input  logic diag_any,
    input  logic fold_req,
    output logic out_enable,
    output logic diag_pull,
    output logic vol_reduce
);
    localparam int SW = $clog2(SOFT_CYC + 1);

    sup_state_t    state, state_nx;
    logic [SW-1:0] soft_cnt;
    logic          need_rs, need_rs_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (float_any) state_nx = ST_FLOAT;              // T_TRIP
            end
            ST_FLOAT: begin
                if (!float_any) begin
                    state_nx = need_rs ? ST_SOFT : ST_RUN;       // T_RESTART / T_RESUME
                end
            end
            ST_SOFT: begin
                if (float_any)           state_nx = ST_FLOAT;    // T_TRIP
                else if (soft_cnt == '0) state_nx = ST_RUN;      // T_READY
            end
            default: state_nx = ST_FLOAT;
        endcase
    end

    always_comb begin
        need_rs_nx = restart_any
                  || (need_rs && state_nx == ST_FLOAT)
                  || (state == ST_SOFT && state_nx == ST_FLOAT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_SOFT;
            soft_cnt <= SW'(SOFT_CYC);
            need_rs  <= 1'b0;
        end else begin
            state   <= state_nx;
            need_rs <= need_rs_nx;
            if (state_nx == ST_SOFT && state != ST_SOFT) begin
                soft_cnt <= SW'(SOFT_CYC);
            end else if (state == ST_SOFT && soft_cnt != '0) begin
                soft_cnt <= soft_cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diag_pull  <= 1'b0;
            vol_reduce <= 1'b0;
        end else begin
            diag_pull  <= diag_any;
            vol_reduce <= fold_req;
        end
    end

    assign out_enable = (state == ST_RUN);
endmodule

// File: rtl/amp_fault_supervisor.sv
module amp_fault_supervisor
    import afp_pkg::*;
#(
    parameter int DELAY_CYC = 100,
    parameter int SOFT_CYC  = 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 temp_warn,
    input  logic                 temp_diss,
    input  logic                 temp_crit,
    input  logic                 over_current,
    input  logic                 supply_high,
    input  logic                 supply_low,
    input  logic                 rail_low,
    input  logic                 out_window,
    input  logic                 pll_unlock,
    input  logic                 pll_slow,
    input  logic                 flag_rd,
    output logic                 out_enable,
    output logic                 diag_pull,
    output logic                 vol_reduce,
    output logic [NUM_CLASS-1:0] fault_flags
);
    logic [NUM_CLASS-1:0] cond;
    logic [NUM_CLASS-1:0] hold;

    always_comb begin
        cond           = '0;
        cond[CL_FOLD]  = temp_warn;
        cond[CL_OTEMP] = temp_crit;
        cond[CL_OCUR]  = over_current;
        cond[CL_OVOLT] = supply_high;
        cond[CL_UVOLT] = supply_low || rail_low;
        cond[CL_ODISS] = temp_diss && over_current;
        cond[CL_WIN]   = out_window;
        cond[CL_LOCK]  = pll_unlock;
        cond[CL_FREQ]  = pll_slow;
    end

    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_class
        if (AUTO_MASK[g]) begin : g_auto
            afp_recovery_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
                .clk   (clk),
                .rst_n (rst_n),
                .cond  (cond[g]),
                .hold  (hold[g])
            );
        end else begin : g_level
            assign hold[g] = cond[g];
        end
    end

    afp_flag_bank #(.N(NUM_CLASS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (cond),
        .rd_clr  (flag_rd),
        .flags   (fault_flags)
    );

    afp_state_ctrl #(.SOFT_CYC(SOFT_CYC)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .float_any   (|(hold & FLOAT_MASK)),
        .restart_any (|(hold & RESTART_MASK)),
        .diag_any    (|(hold & DIAG_MASK)),
        .fold_req    (hold[CL_FOLD]),
        .out_enable  (out_enable),
        .diag_pull   (diag_pull),
        .vol_reduce  (vol_reduce)
    );
endmodule

// File: rtl/amp_fault_supervisor_chk.sv
module amp_fault_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       temp_warn,
    input logic       temp_diss,
    input logic       temp_crit,
    input logic       over_current,
    input logic       supply_high,
    input logic       supply_low,
    input logic       rail_low,
    input logic       out_window,
    input logic       pll_unlock,
    input logic       pll_slow,
    input logic       flag_rd,
    input logic       out_enable,
    input logic       diag_pull,
    input logic       vol_reduce,
    input logic [8:0] fault_flags
);
    assert_fold_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        temp_warn |=> vol_reduce);

    assert_auto_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_crit || over_current) |=> (!out_enable && diag_pull));

    assert_restart_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_high || supply_low || rail_low || out_window) |=> (!out_enable && diag_pull));

    assert_diss_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_diss && over_current) |=> fault_flags[5]);

    assert_pll_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_unlock || pll_slow) |=> !out_enable);

    assert_sticky_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_rd |=> ((fault_flags | $past(fault_flags)) == fault_flags));
endmodule

bind amp_fault_supervisor amp_fault_supervisor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .temp_warn    (temp_warn),
    .temp_diss    (temp_diss),
    .temp_crit    (temp_crit),
    .over_current (over_current),
    .supply_high  (supply_high),
    .supply_low   (supply_low),
    .rail_low     (rail_low),
    .out_window   (out_window),
    .pll_unlock   (pll_unlock),
    .pll_slow     (pll_slow),
    .flag_rd      (flag_rd),
    .out_enable   (out_enable),
    .diag_pull    (diag_pull),
    .vol_reduce   (vol_reduce),
    .fault_flags  (fault_flags)
);

// File: tb/tb_amp_fault_supervisor.sv
module tb_amp_fault_supervisor;
    localparam int D = 5;
    localparam int S = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic temp_warn = 0, temp_diss = 0, temp_crit = 0, over_current = 0;
    logic supply_high = 0, supply_low = 0, rail_low = 0, out_window = 0;
    logic pll_unlock = 0, pll_slow = 0, flag_rd = 0;
    logic       out_enable, diag_pull, vol_reduce;
    logic [8:0] fault_flags;

    always #10 clk = ~clk;

    amp_fault_supervisor #(.DELAY_CYC(D), .SOFT_CYC(S)) dut (
        .clk(clk), .rst_n(rst_n),
        .temp_warn(temp_warn), .temp_diss(temp_diss), .temp_crit(temp_crit),
        .over_current(over_current), .supply_high(supply_high),
        .supply_low(supply_low), .rail_low(rail_low), .out_window(out_window),
        .pll_unlock(pll_unlock), .pll_slow(pll_slow), .flag_rd(flag_rd),
        .out_enable(out_enable), .diag_pull(diag_pull), .vol_reduce(vol_reduce),
        .fault_flags(fault_flags)
    );

    typedef struct {
        logic       oe;
        logic       dg;
        logic       vr;
        logic [8:0] fl;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic oe, input logic dg, input logic vr,
                              input logic [8:0] fl, input string tag);
        exp_t e;
        e.oe = oe; e.dg = dg; e.vr = vr; e.fl = fl; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic rd_clear();
        flag_rd = 1'b1;
        step(1);
        flag_rd = 1'b0;
    endtask

    // monitor: compares queued expectations against the ports
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (out_enable !== e.oe || diag_pull !== e.dg ||
                    vol_reduce !== e.vr || fault_flags !== e.fl) begin
                    n_errors++;
                    $display("FAIL %s: got oe=%b diag=%b vol=%b flags=%h, expected oe=%b diag=%b vol=%b flags=%h",
                             e.tag, out_enable, diag_pull, vol_reduce, fault_flags,
                             e.oe, e.dg, e.vr, e.fl);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        step(3);
        expect_out(0, 0, 0, 9'h000, "R1 reset state");
        step(1);
        rst_n = 1'b1;
        step(S);
        expect_out(0, 0, 0, 9'h000, "R1 soft-start still running");
        step(1);
        expect_out(1, 0, 0, 9'h000, "R1 outputs enabled after soft-start");

        // R2 thermal foldback
        temp_warn = 1; step(1);
        expect_out(1, 0, 1, 9'h001, "R2 foldback keeps switching");
        step(2);
        expect_out(1, 0, 1, 9'h001, "R2 foldback held");
        temp_warn = 0; step(1);
        expect_out(1, 0, 0, 9'h001, "R2/R9 foldback released, flag sticky");
        rd_clear();
        expect_out(1, 0, 0, 9'h000, "R9 read clears flags");

        // R3 overtemperature auto recovery
        temp_crit = 1; step(1);
        expect_out(0, 1, 0, 9'h002, "R3 overtemp trips");
        step(2);
        temp_crit = 0; step(D);
        expect_out(0, 1, 0, 9'h002, "R3 still floated at end of delay");
        step(1);
        expect_out(1, 0, 0, 9'h002, "R3 direct recovery after delay");
        rd_clear();

        // R4 reassert inside the delay window
        over_current = 1; step(1);
        over_current = 0; step(3);
        expect_out(0, 1, 0, 9'h004, "R4 inside first delay");
        over_current = 1; step(1);
        over_current = 0; step(D);
        expect_out(0, 1, 0, 9'h004, "R4 delay restarted");
        step(1);
        expect_out(1, 0, 0, 9'h004, "R4 recovery after full delay");
        rd_clear();

        // R5 overvoltage restart
        supply_high = 1; step(1);
        expect_out(0, 1, 0, 9'h008, "R5 overvoltage trips");
        supply_high = 0; step(1);
        expect_out(0, 0, 0, 9'h008, "R5 diag released on clear");
        step(S);
        expect_out(0, 0, 0, 9'h008, "R5 soft-start still running");
        step(1);
        expect_out(1, 0, 0, 9'h008, "R5 enabled after soft-start");
        rd_clear();

        // R5 undervoltage via low 3.3 V rail
        rail_low = 1; step(1);
        expect_out(0, 1, 0, 9'h010, "R5 rail low trips");
        rail_low = 0; step(S + 1);
        expect_out(0, 0, 0, 9'h010, "R5 rail low soft-start");
        step(1);
        expect_out(1, 0, 0, 9'h010, "R5 rail low recovered");
        rd_clear();

        // R5 output window fault
        out_window = 1; step(2);
        expect_out(0, 1, 0, 9'h040, "R5 window trips");
        out_window = 0; step(S + 1);
        expect_out(0, 0, 0, 9'h040, "R5 window soft-start");
        step(1);
        expect_out(1, 0, 0, 9'h040, "R5 window recovered");
        rd_clear();

        // R6 / R8 overdissipation overlapping overcurrent
        temp_diss = 1; step(2);
        expect_out(1, 0, 0, 9'h000, "R6 temp_diss alone ignored");
        over_current = 1; step(1);
        expect_out(0, 1, 0, 9'h024, "R6 overdissipation trips");
        temp_diss = 0; step(3);
        expect_out(0, 1, 0, 9'h024, "R8 overcurrent keeps outputs floated");
        over_current = 0; step(D + S + 1);
        expect_out(0, 0, 0, 9'h024, "R8 soft-start after last recovery");
        step(1);
        expect_out(1, 0, 0, 9'h024, "R8 enabled after delay and soft-start");
        rd_clear();

        // R7 PLL faults
        pll_unlock = 1; step(1);
        expect_out(0, 0, 0, 9'h080, "R7 unlock floats, diag released");
        pll_unlock = 0; step(S + 1);
        expect_out(0, 0, 0, 9'h080, "R7 unlock soft-start");
        step(1);
        expect_out(1, 0, 0, 9'h080, "R7 unlock recovered");
        rd_clear();
        pll_slow = 1; step(2);
        expect_out(0, 0, 0, 9'h100, "R7 slow PLL floats, diag released");

        // R9 read while the condition is still present
        rd_clear();
        expect_out(0, 0, 0, 9'h100, "R9 live condition re-sets flag");
        pll_slow = 0; step(S + 2);
        expect_out(1, 0, 0, 9'h100, "R7 slow PLL recovered");
        rd_clear();
        expect_out(1, 0, 0, 9'h000, "R9 flags cleared");

        step(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule